// File: doc/BRIEF.md
# ECC Error Capture Register Unit

This unit sits beside a memory controller's error detection logic and keeps a software-visible record of ECC error events. Each event arrives as a single-cycle valid pulse carrying the failing address, the ID of the bus master that issued the transfer, the bank index, the direction of the access, whether the error was correctable, and whether the master wants the address frozen. The unit keeps an error address register, two status registers holding one field group for each of four masters, and one error flag for each bank.

Software never addresses these registers directly. It first writes a register index through a select strobe. It then reads the selected register on the data port, or writes it through a data strobe. Status bits are write-one-to-clear. A locked address stays put until software clears the lock flag that froze it.

Register indices are 0 for the address, 1 for status A and 2 for status B; index 3 is unused. Every master field group is five bits wide. Bits [2:0] hold the error type, bit 3 the direction and bit 4 the lock flag. Status A carries master 0 in bits [4:0], master 1 in bits [9:5] and the bank flags in bits [19:16], with bank b at bit 16+b. Status B carries master 2 in bits [4:0] and master 3 in bits [9:5].

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero, the lock is open and the select index is 0.
- R2: While the lock is open, every event, correctable or uncorrectable, loads its address into the address register on the clock edge that samples the pulse.
- R3: An event with a lock request that arrives while the lock is open still loads its address and sets the requesting master's lock flag (group bit 4). Once any lock flag is set, later events leave the address register unchanged.
- R4: Clearing the set lock flag through either status register opens the lock, and the next event loads its address again.
- R5: An uncorrectable event sets its master's type field to 3'b010. A correctable event leaves the type field untouched. The field only ever holds 3'b000 or 3'b010.
- R6: An uncorrectable event sets its master's direction bit to 1 for a read and 0 for a write.
- R7: Every event sets the flag of its bank, at status A bit 16+bank.
- R8: A data write to a status register clears each bit written as 1 and keeps each bit written as 0.
- R9: When an event sets a status bit in the same cycle that a data write clears it, the bit ends set.
- R10: A select write loads the register index from data bits [1:0], and the data port then shows the selected register. Index 3 and every unused bit read as zero, and data writes to index 0 or index 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event pulse |
| ev_addr | input | ADDR_W (32) | Failing address |
| ev_master | input | 2 | Master ID of the failing transfer |
| ev_bank | input | 2 | Bank index of the failing transfer |
| ev_read | input | 1 | 1 = read access, 0 = write access |
| ev_uncorr | input | 1 | 1 = uncorrectable, 0 = correctable |
| ev_lock | input | 1 | Master requests address locking |
| cfg_sel_we | input | 1 | Load register index from cfg_wdata[1:0] |
| cfg_data_we | input | 1 | Write cfg_wdata to the selected register |
| cfg_wdata | input | 32 | Software write data |
| cfg_rdata | output | 32 | Contents of the selected register |

## Verification
Events, select writes and data writes all take effect on the clock edge that samples them. The read port is a combinational view of the registers, so each result is visible one edge after its stimulus. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It compares the data port with the model at the next falling edge, once per clock. Lock, release and event-wins cases are timed so that the model's view of the lock before the edge decides whether the address moves, which matches the one-edge latency.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;
   localparam int GRP_W        = 5;
   localparam int GRPS_PER_REG = 2;
   localparam int BANK_LSB     = 16;

   localparam logic [2:0] ETYPE_NONE   = 3'b000;
   localparam logic [2:0] ETYPE_UNCORR = 3'b010;

   typedef enum logic [1:0] {
      SEL_ADDR  = 2'd0,
      SEL_STATA = 2'd1,
      SEL_STATB = 2'd2,
      SEL_NONE  = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic       lock;
      logic       rd;
      logic [2:0] etype;
   } master_grp_t;
endpackage

// File: rtl/ecc_err_master_slot.sv
module ecc_err_master_slot
   import ecc_err_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic               uncorr,
   input  logic               rd,
   input  logic               lock_take,
   input  logic [GRP_W-1:0]   clr,
   output master_grp_t        grp
);
   master_grp_t grp_q;
   logic        ue_hit;

   assign ue_hit = hit && uncorr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_q <= '0;
      end else begin
         if (ue_hit) grp_q.etype <= ETYPE_UNCORR;
         else        grp_q.etype <= grp_q.etype & ~clr[2:0];

         if (ue_hit)      grp_q.rd <= rd;
         else if (clr[3]) grp_q.rd <= 1'b0;

         if (lock_take)   grp_q.lock <= 1'b1;
         else if (clr[4]) grp_q.lock <= 1'b0;
      end
   end

   assign grp = grp_q;

   // R5
   etype_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_q.etype == ETYPE_NONE) || (grp_q.etype == ETYPE_UNCORR));

   // R6
   rw_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ue_hit |=> (grp_q.rd == $past(rd)));

   // R9
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_hit && clr[1]) |=> (grp_q.etype == ETYPE_UNCORR));

   // R8
   rw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[3] && !ue_hit) |=> !grp_q.rd);
endmodule

// File: rtl/ecc_err_addr_cap.sv
module ecc_err_addr_cap #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic              locked,
   input  logic [ADDR_W-1:0] ev_addr,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)                  addr_q <= '0;
      else if (ev_valid && !locked) addr_q <= ev_addr;
   end

   // R3
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(addr_q));

   // R2
   open_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !locked) |=> (addr_q == $past(ev_addr)));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_err_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int N_MASTERS = 4,
   parameter int N_BANKS   = 4,
   localparam int MID_W    = $clog2(N_MASTERS),
   localparam int BID_W    = $clog2(N_BANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [MID_W-1:0]  ev_master,
   input  logic [BID_W-1:0]  ev_bank,
   input  logic              ev_read,
   input  logic              ev_uncorr,
   input  logic              ev_lock,
   input  logic              cfg_sel_we,
   input  logic              cfg_data_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata
);
   localparam int N_STAT = N_MASTERS / GRPS_PER_REG;

   if (ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ecc_err_log: ADDR_W must not exceed DATA_W");
   end
   if (N_MASTERS != 4 || N_BANKS != 4) begin : g_bad_counts
      $error("ecc_err_log: layout needs four masters and four banks");
   end
   if (DATA_W < BANK_LSB + N_BANKS) begin : g_bad_data_w
      $error("ecc_err_log: DATA_W too narrow for bank flags");
   end

   cfg_sel_e                        sel_q;
   logic [N_STAT-1:0][DATA_W-1:0]   clr_reg;
   logic [N_STAT-1:0][DATA_W-1:0]   stat_img;
   master_grp_t                     grp [N_MASTERS];
   logic [N_MASTERS-1:0]            lock_vec;
   logic [N_BANKS-1:0]              bank_q;
   logic                            locked;
   logic [ADDR_W-1:0]               addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          sel_q <= SEL_ADDR;
      else if (cfg_sel_we) sel_q <= cfg_sel_e'(cfg_wdata[1:0]);
   end

   always_comb begin
      clr_reg = '0;
      if (cfg_data_we && sel_q == SEL_STATA) clr_reg[0] = cfg_wdata;
      if (cfg_data_we && sel_q == SEL_STATB) clr_reg[1] = cfg_wdata;
   end

   assign locked = |lock_vec;

   ecc_err_addr_cap #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_valid (ev_valid),
      .locked   (locked),
      .ev_addr  (ev_addr),
      .addr_q   (addr_q)
   );

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_master
      localparam int RI = g / GRPS_PER_REG;
      localparam int OF = (g % GRPS_PER_REG) * GRP_W;
      logic hit;
      assign hit = ev_valid && (ev_master == MID_W'(g));

      ecc_err_master_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .hit       (hit),
         .uncorr    (ev_uncorr),
         .rd        (ev_read),
         .lock_take (hit && ev_lock && !locked),
         .clr       (clr_reg[RI][OF +: GRP_W]),
         .grp       (grp[g])
      );
      assign lock_vec[g] = grp[g].lock;
   end

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)                                bank_q[b] <= 1'b0;
         else if (ev_valid && ev_bank == BID_W'(b)) bank_q[b] <= 1'b1;
         else if (clr_reg[0][BANK_LSB + b])         bank_q[b] <= 1'b0;
      end
   end

   always_comb begin
      stat_img = '0;
      for (int g = 0; g < N_MASTERS; g++)
         stat_img[g / GRPS_PER_REG][(g % GRPS_PER_REG) * GRP_W +: GRP_W] = grp[g];
      stat_img[0][BANK_LSB +: N_BANKS] = bank_q;
   end

   always_comb begin
      case (sel_q)
         SEL_ADDR:  cfg_rdata = DATA_W'(addr_q);
         SEL_STATA: cfg_rdata = stat_img[0];
         SEL_STATB: cfg_rdata = stat_img[1];
         default:   cfg_rdata = '0;
      endcase
   end

   // R7
   bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> bank_q[$past(ev_bank)]);

   // R3
   single_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lock_vec));
endmodule

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ev_valid = 1'b0;
   logic [31:0] ev_addr = '0;
   logic [1:0]  ev_master = '0;
   logic [1:0]  ev_bank = '0;
   logic        ev_read = 1'b0;
   logic        ev_uncorr = 1'b0;
   logic        ev_lock = 1'b0;
   logic        cfg_sel_we = 1'b0;
   logic        cfg_data_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;

   int checks = 0;
   int failures = 0;

   // behavioural model
   logic [31:0] m_addr;
   logic [2:0]  m_type [4];
   logic        m_rw   [4];
   logic        m_lock [4];
   logic [3:0]  m_bank;
   logic [1:0]  m_sel;

   always #5 clk = ~clk;

   ecc_err_log dut (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
      .ev_master(ev_master), .ev_bank(ev_bank), .ev_read(ev_read),
      .ev_uncorr(ev_uncorr), .ev_lock(ev_lock), .cfg_sel_we(cfg_sel_we),
      .cfg_data_we(cfg_data_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
   );

   function automatic logic [4:0] mgrp(int g);
      return {m_lock[g], m_rw[g], m_type[g]};
   endfunction

   function automatic logic [31:0] mread();
      logic [31:0] v = '0;
      case (m_sel)
         2'd0: v = m_addr;
         2'd1: begin v[4:0] = mgrp(0); v[9:5] = mgrp(1); v[19:16] = m_bank; end
         2'd2: begin v[4:0] = mgrp(2); v[9:5] = mgrp(3); end
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic mclr(int g, logic [4:0] w);
      m_type[g] = m_type[g] & ~w[2:0];
      if (w[3]) m_rw[g] = 1'b0;
      if (w[4]) m_lock[g] = 1'b0;
   endtask

   task automatic mreset();
      m_addr = '0; m_bank = '0; m_sel = '0;
      for (int g = 0; g < 4; g++) begin
         m_type[g] = '0; m_rw[g] = 1'b0; m_lock[g] = 1'b0;
      end
   endtask

   task automatic mupdate();
      logic was_locked;
      was_locked = m_lock[0] | m_lock[1] | m_lock[2] | m_lock[3];
      if (cfg_data_we) begin
         if (m_sel == 2'd1) begin
            mclr(0, cfg_wdata[4:0]); mclr(1, cfg_wdata[9:5]);
            m_bank = m_bank & ~cfg_wdata[19:16];
         end else if (m_sel == 2'd2) begin
            mclr(2, cfg_wdata[4:0]); mclr(3, cfg_wdata[9:5]);
         end
      end
      if (ev_valid) begin
         if (!was_locked) m_addr = ev_addr;
         if (ev_lock && !was_locked) m_lock[ev_master] = 1'b1;
         if (ev_uncorr) begin
            m_type[ev_master] = 3'b010;
            m_rw[ev_master] = ev_read;
         end
         m_bank[ev_bank] = 1'b1;
      end
      if (cfg_sel_we) m_sel = cfg_wdata[1:0];
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(string tag);
      @(posedge clk);
      mupdate();
      @(negedge clk);
      check(tag, cfg_rdata, mread());
      ev_valid = 1'b0; ev_lock = 1'b0; cfg_sel_we = 1'b0; cfg_data_we = 1'b0;
   endtask

   task automatic ev(logic [31:0] a, int m, int b, bit rd, bit ue, bit lk, string tag);
      ev_valid = 1'b1; ev_addr = a; ev_master = 2'(m); ev_bank = 2'(b);
      ev_read = rd; ev_uncorr = ue; ev_lock = lk;
      step(tag);
   endtask

   task automatic sel(int idx, string tag);
      cfg_sel_we = 1'b1; cfg_wdata = 32'(idx);
      step(tag);
   endtask

   task automatic wr(logic [31:0] d, string tag);
      cfg_data_we = 1'b1; cfg_wdata = d;
      step(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      mreset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 addr after reset", cfg_rdata, 32'h0);
      sel(1, "R1 stat A after reset"); check("R1 stat A zero", cfg_rdata, 32'h0);
      sel(2, "R1 stat B after reset"); check("R1 stat B zero", cfg_rdata, 32'h0);

      // correctable, master 1, bank 2, then uncorrectable read on master 0
      sel(0, "R10 select addr");
      ev(32'hA000_1000, 1, 2, 1, 0, 0, "R2 correctable capture");
      check("R2 addr literal", cfg_rdata, 32'hA000_1000);
      ev(32'hB000_2000, 0, 0, 1, 1, 0, "R2 uncorrectable capture");
      sel(1, "R10 select stat A");
      check("R5 R6 R7 stat A literal", cfg_rdata, 32'h0005_000A);
      ev(32'hB000_3000, 3, 3, 0, 1, 0, "R6 write direction");
      sel(2, "R10 select stat B");
      check("R6 master3 write", cfg_rdata, 32'h0000_0040);

      // lock from master 2, later events must not move the address
      ev(32'hC000_0040, 2, 1, 1, 1, 1, "R3 lock request");
      check("R3 lock flag in stat B", cfg_rdata, 32'h0000_005A);
      ev(32'hD000_0000, 0, 0, 0, 0, 1, "R3 event while locked");
      ev(32'hD000_0004, 1, 2, 1, 1, 0, "R3 event while locked");
      sel(0, "R10 select addr");
      check("R3 addr frozen", cfg_rdata, 32'hC000_0040);

      // data write to addr index ignored
      wr(32'hFFFF_FFFF, "R10 addr write ignored");
      sel(3, "R10 select unused");
      wr(32'hFFFF_FFFF, "R10 unused write ignored");
      check("R10 unused reads zero", cfg_rdata, 32'h0);

      // zeros keep, ones clear
      sel(2, "R10 select stat B");
      wr(32'h0, "R8 zero write keeps");
      wr(32'h0000_0010, "R4 release through stat B");
      check("R4 lock bit cleared", cfg_rdata, 32'h0000_004A);
      ev(32'hE000_0100, 3, 0, 1, 0, 0, "R4 capture after release");
      sel(0, "R10 select addr");
      check("R4 addr moves", cfg_rdata, 32'hE000_0100);

      // lock on master 1, release through stat A
      ev(32'hE000_0200, 1, 1, 0, 1, 1, "R3 lock master1");
      ev(32'hE000_0300, 2, 1, 0, 0, 0, "R3 hold");
      sel(1, "R10 select stat A");
      wr(32'h0004_0200, "R4 R8 release via stat A, clear bank2");
      sel(0, "R10 select addr");
      check("R3 addr held before release", cfg_rdata, 32'hE000_0200);
      ev(32'hE000_0400, 2, 3, 0, 0, 0, "R4 capture after stat A release");

      // event wins over same-cycle clear
      sel(1, "R10 select stat A");
      ev_valid = 1'b1; ev_addr = 32'hF000_0000; ev_master = 2'd0; ev_bank = 2'd1;
      ev_read = 1'b0; ev_uncorr = 1'b1; ev_lock = 1'b0;
      cfg_data_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
      step("R9 event wins over clear");
      check("R9 stat A literal", cfg_rdata, 32'h0002_0002);
      wr(32'h0000_0002, "R8 partial type clear");
      wr(32'hFFFF_FFFF, "R8 full clear");
      check("R8 stat A empty", cfg_rdata, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule